// File: doc/BRIEF.md
# Integer ALU with condition bit

This is the integer execution unit of a small RISC core. Each cycle it can accept one operation: a 5-bit operation code, two 32-bit operands and the core's current condition bit. Any immediate reaching `opb` has already been sign- or zero-extended by decode. The unit returns a result word, a write enable for the destination register and the next value of the condition bit. The register file, decode and memory access sit outside this block.

One condition bit does several jobs. It holds the signed overflow of the checking add and subtract, the carry or borrow in and out of the extended add and subtract, and the outcome of a compare. Operations that do not touch the bit pass `cond_in` through to `cond_out` unchanged.

Every operation except divide and remainder completes in one cycle. Divide and remainder use an iterative restoring divider run by a three-state machine:
- `DV_IDLE` moves to `DV_CALC` on a start.
- `DV_CALC` does one quotient bit per cycle. It moves to `DV_FIX` after the last bit.
- `DV_FIX` applies the result signs. It returns to `DV_IDLE` as the result is delivered.

While the divider is busy, new operations are refused. A zero divisor never starts the divider: it completes in one cycle with the register write suppressed.

Top module: `cbit_alu`

## Requirements
- R1: An operation is accepted on a rising edge where `op_valid`=1 and `busy`=0. Apart from a divide or remainder with a non-zero divisor, every accepted operation pulses `res_valid` for one cycle right after the accepting edge.
- R2: Codes 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 move (b), 6 negate (-b) and 7 invert (~b) write their result with `res_wen`=1 and leave `cond_out` equal to `cond_in`.
- R3: Code 11 (a+b) and code 12 (a-b) write the 32-bit wrapped result and set `cond_out` to the signed overflow of that operation.
- R4: Code 13 writes a+b+cond_in and code 14 writes a-b-cond_in. Each sets `cond_out` to the carry out (13) or the borrow out (14) of the unsigned 32-bit operation.
- R5: Code 15 sets `cond_out` to signed a<b and code 16 sets it to unsigned a<b. Both give `res_wen`=0.
- R6: Code 8 shifts a left logically, code 9 shifts it right logically and code 10 shifts it right arithmetically. Only `opb[4:0]` gives the shift amount. All three leave `cond_out`=`cond_in`.
- R7: Code 17 writes `opb[15:0]` into bits 31:16 with bits 15:0 cleared, and leaves `cond_out`=`cond_in`.
- R8: Codes 18 signed divide, 19 unsigned divide, 20 signed remainder and 21 unsigned remainder with a non-zero divisor behave as follows. `busy` is high from the accepting edge until the result. `res_valid` rises 33 edges after acceptance (WIDTH+1), with `res_wen`=1 and `cond_out` equal to the `cond_in` that was accepted.
- R9: Signed divide truncates toward zero and the signed remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value, with a remainder of 0.
- R10: Codes 18 to 21 with `opb`=0 complete one cycle after acceptance with `res_wen`=0 and `cond_out`=`cond_in`, and never raise `busy`.
- R11: `op_valid` while `busy`=1 is ignored. It produces no result, and it does not disturb the divide in flight.
- R12: After reset, `res_valid`=0 and `busy`=0.
- R13: Codes 22 to 31 complete in one cycle with `res_wen`=0 and `cond_out`=`cond_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 5 | Operation code |
| opa | input | 32 | First operand; dividend and shifted value |
| opb | input | 32 | Second operand; divisor, shift amount, immediate |
| cond_in | input | 1 | Current condition bit |
| busy | output | 1 | Divider occupied; operations refused |
| res_valid | output | 1 | One-cycle pulse: result fields valid |
| res_data | output | 32 | Result word |
| res_wen | output | 1 | Destination register should be written |
| cond_out | output | 1 | Next condition bit |

## Verification
Single-cycle operations and zero-divisor divides have their result due in the cycle after the accepting edge. A divide with a non-zero divisor is due 33 edges after acceptance, with `busy` high in every cycle before that. The bench counts edges from acceptance with a behavioural model of each operation. It samples on the falling edge and checks both `res_valid` and `busy` in every cycle of that window, so a result that arrives early, late or twice is reported. It also compares data, write enable and condition bit in the cycle the result is due. One divide has a stray request injected while it is busy, to show the request is refused.

// File: rtl/cbit_alu_pkg.sv
package cbit_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_AND  = 5'd2,
        OP_OR   = 5'd3,
        OP_XOR  = 5'd4,
        OP_MOVE = 5'd5,
        OP_NEG  = 5'd6,
        OP_INV  = 5'd7,
        OP_SHL  = 5'd8,
        OP_SHR  = 5'd9,
        OP_SHRA = 5'd10,
        OP_ADDV = 5'd11,
        OP_SUBV = 5'd12,
        OP_ADDC = 5'd13,
        OP_SUBC = 5'd14,
        OP_CMPS = 5'd15,
        OP_CMPU = 5'd16,
        OP_HILD = 5'd17,
        OP_DIVS = 5'd18,
        OP_DIVU = 5'd19,
        OP_REMS = 5'd20,
        OP_REMU = 5'd21
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_mode_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_CALC = 2'd1,
        DV_FIX  = 2'd2
    } div_state_e;

    function automatic logic is_div_code(input logic [4:0] code);
        return (code >= 5'd18) && (code <= 5'd21);
    endfunction

endpackage

// File: rtl/cbit_alu_shift.sv
module cbit_alu_shift
    import cbit_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  shift_mode_e      mode,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [SHW+1];
    logic             fill;

    assign fill     = (mode == SH_ARITH) ? din[WIDTH-1] : 1'b0;
    assign stage[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int D = 1 << i;
        always_comb begin
            if (!amt[i]) begin
                stage[i+1] = stage[i];
            end else if (mode == SH_LEFT) begin
                stage[i+1] = {stage[i][WIDTH-1-D:0], {D{1'b0}}};
            end else begin
                stage[i+1] = {{D{fill}}, stage[i][WIDTH-1:D]};
            end
        end
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/cbit_alu_arith.sv
module cbit_alu_arith
    import cbit_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW = $clog2(WIDTH),
    localparam int HW  = WIDTH / 2
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] result,
    output logic             wen,
    output logic             cout
);

    logic [WIDTH:0]   carry_sum;
    logic [WIDTH:0]   borrow_diff;
    logic [WIDTH-1:0] plain_sum;
    logic [WIDTH-1:0] plain_diff;
    logic [WIDTH-1:0] shifted;
    logic             sum_ovf;
    logic             diff_ovf;
    shift_mode_e      sh_mode;

    assign plain_sum   = a + b;
    assign plain_diff  = a - b;
    assign carry_sum   = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign borrow_diff = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
    assign sum_ovf     = (a[WIDTH-1] == b[WIDTH-1]) && (plain_sum[WIDTH-1] != a[WIDTH-1]);
    assign diff_ovf    = (a[WIDTH-1] != b[WIDTH-1]) && (plain_diff[WIDTH-1] != a[WIDTH-1]);

    always_comb begin
        unique case (op)
            OP_SHL:  sh_mode = SH_LEFT;
            OP_SHRA: sh_mode = SH_ARITH;
            default: sh_mode = SH_RIGHT;
        endcase
    end

    cbit_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .din  (a),
        .amt  (b[SHW-1:0]),
        .mode (sh_mode),
        .dout (shifted)
    );

    always_comb begin
        result = '0;
        wen    = 1'b1;
        cout   = cin;
        unique case (op)
            OP_ADD:  result = plain_sum;
            OP_SUB:  result = plain_diff;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_MOVE: result = b;
            OP_NEG:  result = '0 - b;
            OP_INV:  result = ~b;
            OP_SHL, OP_SHR, OP_SHRA: result = shifted;
            OP_ADDV: begin
                result = plain_sum;
                cout   = sum_ovf;
            end
            OP_SUBV: begin
                result = plain_diff;
                cout   = diff_ovf;
            end
            OP_ADDC: begin
                result = carry_sum[WIDTH-1:0];
                cout   = carry_sum[WIDTH];
            end
            OP_SUBC: begin
                result = borrow_diff[WIDTH-1:0];
                cout   = borrow_diff[WIDTH];
            end
            OP_CMPS: begin
                wen  = 1'b0;
                cout = $signed(a) < $signed(b);
            end
            OP_CMPU: begin
                wen  = 1'b0;
                cout = a < b;
            end
            OP_HILD: result = {b[HW-1:0], {(WIDTH-HW){1'b0}}};
            default: wen = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbit_alu_div.sv
module cbit_alu_div
    import cbit_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sgn,
    input  logic             rem_sel,
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    output logic             busy,
    output logic             fin,
    output logic [WIDTH-1:0] value
);

    div_state_e       state, state_nx;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] quo;
    logic [WIDTH-1:0] rem;
    logic [WIDTH-1:0] dmag;
    logic             q_neg;
    logic             r_neg;
    logic             rem_q;
    logic [WIDTH:0]   sh;
    logic [WIDTH:0]   trial;
    logic             last_step;

    assign sh        = {rem, quo[WIDTH-1]};
    assign trial     = sh - {1'b0, dmag};
    assign last_step = (cnt == CW'(WIDTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DV_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DV_IDLE: if (start)     state_nx = DV_CALC;
            DV_CALC: if (last_step) state_nx = DV_FIX;
            DV_FIX:                 state_nx = DV_IDLE;
            default:                state_nx = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            quo   <= '0;
            rem   <= '0;
            dmag  <= '0;
            q_neg <= 1'b0;
            r_neg <= 1'b0;
            rem_q <= 1'b0;
        end else begin
            unique case (state)
                DV_IDLE: if (start) begin
                    cnt   <= '0;
                    rem   <= '0;
                    quo   <= (sgn && num[WIDTH-1]) ? ('0 - num) : num;
                    dmag  <= (sgn && den[WIDTH-1]) ? ('0 - den) : den;
                    q_neg <= sgn && (num[WIDTH-1] ^ den[WIDTH-1]);
                    r_neg <= sgn && num[WIDTH-1];
                    rem_q <= rem_sel;
                end
                DV_CALC: begin
                    cnt <= cnt + 1'b1;
                    if (!trial[WIDTH]) begin
                        rem <= trial[WIDTH-1:0];
                        quo <= {quo[WIDTH-2:0], 1'b1};
                    end else begin
                        rem <= sh[WIDTH-1:0];
                        quo <= {quo[WIDTH-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy  = (state != DV_IDLE);
    assign fin   = (state == DV_FIX);
    assign value = rem_q ? (r_neg ? ('0 - rem) : rem)
                         : (q_neg ? ('0 - quo) : quo);

endmodule

// File: rtl/cbit_alu.sv
module cbit_alu
    import cbit_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [4:0]       op_code,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cond_in,
    output logic             busy,
    output logic             res_valid,
    output logic [WIDTH-1:0] res_data,
    output logic             res_wen,
    output logic             cond_out
);

    alu_op_e          op_e;
    logic             accept;
    logic             div_op;
    logic             div_zero;
    logic             div_start;
    logic [WIDTH-1:0] ar_res;
    logic             ar_wen;
    logic             ar_cout;
    logic             dv_busy;
    logic             dv_fin;
    logic [WIDTH-1:0] dv_val;
    logic             cond_hold;

    assign op_e      = alu_op_e'(op_code);
    assign accept    = op_valid && !dv_busy;
    assign div_op    = is_div_code(op_code);
    assign div_zero  = (opb == '0);
    assign div_start = accept && div_op && !div_zero;
    assign busy      = dv_busy;

    cbit_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op     (op_e),
        .a      (opa),
        .b      (opb),
        .cin    (cond_in),
        .result (ar_res),
        .wen    (ar_wen),
        .cout   (ar_cout)
    );

    cbit_alu_div #(.WIDTH(WIDTH)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .sgn     ((op_e == OP_DIVS) || (op_e == OP_REMS)),
        .rem_sel ((op_e == OP_REMS) || (op_e == OP_REMU)),
        .num     (opa),
        .den     (opb),
        .busy    (dv_busy),
        .fin     (dv_fin),
        .value   (dv_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_wen   <= 1'b0;
            cond_out  <= 1'b0;
            cond_hold <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (dv_fin) begin
                res_valid <= 1'b1;
                res_data  <= dv_val;
                res_wen   <= 1'b1;
                cond_out  <= cond_hold;
            end else if (accept && !div_op) begin
                res_valid <= 1'b1;
                res_data  <= ar_res;
                res_wen   <= ar_wen;
                cond_out  <= ar_cout;
            end else if (accept && div_zero) begin
                res_valid <= 1'b1;
                res_data  <= '0;
                res_wen   <= 1'b0;
                cond_out  <= cond_in;
            end else if (div_start) begin
                cond_hold <= cond_in;
            end
        end
    end

endmodule

// File: rtl/cbit_alu_chk.sv
module cbit_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [4:0]       op_code,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             cond_in,
    input logic             busy,
    input logic             res_valid,
    input logic [WIDTH-1:0] res_data,
    input logic             res_wen,
    input logic             cond_out
);

    logic acc;
    logic dv;
    assign acc = op_valid && !busy;
    assign dv  = (op_code >= 5'd18) && (op_code <= 5'd21);

    p_quick_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(dv && opb != '0) |=> res_valid);

    p_compare_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (op_code == 5'd15 || op_code == 5'd16) |=> res_valid && !res_wen);

    p_div_goes_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && dv && opb != '0 |=> busy && !res_valid);

    p_div_finish_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_valid && res_wen);

    p_zero_divisor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && dv && opb == '0 |=> res_valid && !res_wen && !busy && cond_out == $past(cond_in));

    p_quiet_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !res_valid);

    p_unknown_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op_code > 5'd21 |=> res_valid && !res_wen && cond_out == $past(cond_in));

    p_width_sane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_data));

endmodule

bind cbit_alu cbit_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opa       (opa),
    .opb       (opb),
    .cond_in   (cond_in),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_wen   (res_wen),
    .cond_out  (cond_out)
);

// File: tb/sim_cbit_alu.sv
`timescale 1ns/1ps
module sim_cbit_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cond_in = 1'b0;
    logic        busy;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_wen;
    logic        cond_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cbit_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .cond_in(cond_in), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .res_wen(res_wen),
        .cond_out(cond_out)
    );

    // Behavioural reference: expected data, write enable, condition and
    // number of falling-edge samples until the result is due.
    task automatic model(input logic [4:0] code, input logic [31:0] a, b,
                         input logic cin, output logic [31:0] d,
                         output logic w, output logic c, output int lat);
        longint sa, sb, ua, ub, t;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'({32'h0, a}); ub = longint'({32'h0, b});
        d = '0; w = 1'b1; c = cin; lat = 1;
        case (code)
            5'd0:  d = a + b;
            5'd1:  d = a - b;
            5'd2:  d = a & b;
            5'd3:  d = a | b;
            5'd4:  d = a ^ b;
            5'd5:  d = b;
            5'd6:  d = -b;
            5'd7:  d = ~b;
            5'd8:  d = a << b[4:0];
            5'd9:  d = a >> b[4:0];
            5'd10: d = $signed(a) >>> b[4:0];
            5'd11: begin t = sa + sb; d = t[31:0]; c = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
            5'd12: begin t = sa - sb; d = t[31:0]; c = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
            5'd13: begin t = ua + ub + longint'(cin); d = t[31:0]; c = t[32]; end
            5'd14: begin t = ua - ub - longint'(cin); d = t[31:0]; c = (t < 0); end
            5'd15: begin w = 1'b0; c = (sa < sb); end
            5'd16: begin w = 1'b0; c = (ua < ub); end
            5'd17: d = {b[15:0], 16'h0};
            5'd18, 5'd19, 5'd20, 5'd21: begin
                if (b == 0) begin
                    w = 1'b0;
                end else begin
                    lat = 34;
                    if (code == 5'd18)      begin t = sa / sb; d = t[31:0]; end
                    else if (code == 5'd20) begin t = sa % sb; d = t[31:0]; end
                    else if (code == 5'd19) begin t = ua / ub; d = t[31:0]; end
                    else                    begin t = ua % ub; d = t[31:0]; end
                end
            end
            default: w = 1'b0;
        endcase
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] code, input logic [31:0] a, b,
                          input logic cin, input bit inject, input string tag);
        logic [31:0] ed; logic ew, ec; int lat;
        model(code, a, b, cin, ed, ew, ec, lat);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; opa = a; opb = b; cond_in = cin;
        for (int j = 1; j <= lat; j++) begin
            @(negedge clk);
            if (j == 1) begin op_valid = 1'b0; cond_in = ~cin; end
            if (inject && j == 2) begin op_valid = 1'b1; op_code = 5'd0; opa = 32'd5; opb = 32'd6; end
            if (inject && j == 3) op_valid = 1'b0;
            check(tag, res_valid === (j == lat), "res_valid", {31'h0, res_valid}, {31'h0, j == lat});
            check(tag, busy === (lat > 1 && j < lat), "busy", {31'h0, busy}, {31'h0, lat > 1 && j < lat});
            if (j == lat) begin
                check(tag, res_wen === ew, "res_wen", {31'h0, res_wen}, {31'h0, ew});
                check(tag, cond_out === ec, "cond_out", {31'h0, cond_out}, {31'h0, ec});
                if (ew) check(tag, res_data === ed, "res_data", res_data, ed);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", res_valid === 1'b0, "res_valid", {31'h0, res_valid}, 32'h0);
        check("R12", busy === 1'b0, "busy", {31'h0, busy}, 32'h0);
        rst_n = 1'b1;

        // R1 R2: plain ops keep condition bit
        run_op(5'd0, 32'hFFFF_FFFF, 32'h2, 1'b1, 0, "R1");
        run_op(5'd1, 32'h5, 32'h9, 1'b1, 0, "R2");
        run_op(5'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 0, "R2");
        run_op(5'd3, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 0, "R2");
        run_op(5'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 0, "R2");
        run_op(5'd5, 32'h0, 32'hDEAD_BEEF, 1'b1, 0, "R2");
        run_op(5'd6, 32'h0, 32'h0000_0001, 1'b1, 0, "R2");
        run_op(5'd7, 32'h0, 32'h1234_5678, 1'b0, 0, "R2");
        // R6: only low five bits of amount
        run_op(5'd8, 32'h8000_0001, 32'hFFFF_FFE3, 1'b1, 0, "R6");
        run_op(5'd9, 32'h8000_0010, 32'h0000_0024, 1'b0, 0, "R6");
        run_op(5'd10, 32'h8000_0010, 32'h0000_0044, 1'b1, 0, "R6");
        run_op(5'd10, 32'h8000_0000, 32'h0000_001F, 1'b0, 0, "R6");
        // R3: overflow checking
        run_op(5'd11, 32'h7FFF_FFFF, 32'h1, 1'b0, 0, "R3");
        run_op(5'd11, 32'h7FFF_FFFE, 32'h1, 1'b1, 0, "R3");
        run_op(5'd12, 32'h8000_0000, 32'h1, 1'b0, 0, "R3");
        run_op(5'd12, 32'h1, 32'h8000_0000, 1'b0, 0, "R3");
        // R4: carry and borrow through the condition bit
        run_op(5'd13, 32'hFFFF_FFFF, 32'h0, 1'b1, 0, "R4");
        run_op(5'd13, 32'h1, 32'h2, 1'b0, 0, "R4");
        run_op(5'd14, 32'h0, 32'h0, 1'b1, 0, "R4");
        run_op(5'd14, 32'h9, 32'h3, 1'b1, 0, "R4");
        // R5: compares
        run_op(5'd15, 32'hFFFF_FFFF, 32'h1, 1'b0, 0, "R5");
        run_op(5'd16, 32'hFFFF_FFFF, 32'h1, 1'b1, 0, "R5");
        run_op(5'd16, 32'h3, 32'h4, 1'b0, 0, "R5");
        // R7: high-half load
        run_op(5'd17, 32'h0, 32'hABCD_1234, 1'b1, 0, "R7");
        // R8 R9: divider
        run_op(5'd19, 32'd100, 32'd7, 1'b1, 0, "R8");
        run_op(5'd21, 32'd100, 32'd7, 1'b0, 0, "R8");
        run_op(5'd18, 32'hFFFF_FFF9, 32'd2, 1'b1, 0, "R9");
        run_op(5'd20, 32'hFFFF_FFF9, 32'd2, 1'b0, 0, "R9");
        run_op(5'd18, 32'd7, 32'hFFFF_FFFE, 1'b0, 0, "R9");
        run_op(5'd20, 32'd7, 32'hFFFF_FFFE, 1'b1, 0, "R9");
        run_op(5'd18, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R9");
        run_op(5'd20, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R9");
        run_op(5'd19, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 0, "R8");
        // R10: zero divisor
        run_op(5'd18, 32'd55, 32'd0, 1'b1, 0, "R10");
        run_op(5'd21, 32'd55, 32'd0, 1'b0, 0, "R10");
        // R11: request while busy is refused
        run_op(5'd19, 32'd1000, 32'd3, 1'b1, 1, "R11");
        // R13: undefined codes
        run_op(5'd22, 32'h1, 32'h2, 1'b1, 0, "R13");
        run_op(5'd31, 32'h1, 32'h2, 1'b0, 0, "R13");

        @(negedge clk);
        check("R11", res_valid === 1'b0, "res_valid idle", {31'h0, res_valid}, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule